// File: doc/BRIEF.md
# Atomic uop operand collector

This block gathers the micro-ops of one atomic memory instruction into a set of operand registers. An atomic instruction is split upstream into address uops and data uops. They reach the block on two independent valid/ready streams, in any order. Each uop carries a 9-bit operation type. The top three bits of that type are a uop index, and the block uses the index to steer the payload. Address uops load an address slot together with the write-back destination tag. Data uops load a compare or swap slot.

A plain control input names the instruction class: plain atomic, word/doubleword compare-and-swap, or quadword compare-and-swap. From the class, the block knows which indices to expect. It raises a flag once every required data uop is present. It also reports, for each address uop, whether it has arrived, so that each write-back beat can go out with the right tag. A one-cycle clear input starts the next instruction.

Back-pressure rules:
- An uop whose index is expected for the class, but whose slot is already filled, sees ready low. The producer must hold it until a clear.
- Ready is also low in the cycle clear is high.
- An uop with an index the class does not use is accepted and dropped.

Top module: `amo_operand_collector`

## Requirements
- R1: After reset, all received flags are zero, `data_done_o` is low, `sta_got_o` is 2'b00, and both ready outputs are high.
- R2: The uop index is bits 8:6 of the operation type. The class input encodes 0 = plain, 1 = word/doubleword compare-and-swap, 2 = quadword compare-and-swap, and 3 = treated as plain.
- R3: For the plain class, one data uop with index 0 loads the low swap operand. `data_done_o` rises once it is captured.
- R4: For the word/doubleword class, data index 0 loads the low compare operand and data index 1 loads the low swap operand. `data_done_o` needs both, in either order.
- R5: For the quadword class, data indices 0 and 2 load the low and high compare operands, and indices 1 and 3 load the low and high swap operands. `data_done_o` needs all four, in any order.
- R6: Address index 0 sets `sta_got_o[0]`, loads `addr_o` and sets the beat-0 tag. In the quadword class only, address index 2 sets `sta_got_o[1]` and the beat-1 tag. Each is tracked independently of arrival order.
- R7: A uop whose index is not expected for the current class is accepted (ready high) and changes no flag and no operand output.
- R8: A uop with an expected index whose slot is already filled sees ready low, and the stored operand stays unchanged.
- R9: A clear pulse drops both ready outputs in that cycle. From the next cycle on, all received flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear_i | input | 1 | Drop all received flags for the next instruction |
| kind_i | input | 2 | Instruction class (0 plain, 1 W/D CAS, 2 Q CAS, 3 as plain) |
| sta_valid_i | input | 1 | Address uop valid |
| sta_ready_o | output | 1 | Address uop ready |
| sta_op_i | input | 9 | Address uop operation type, index in bits 8:6 |
| sta_tag_i | input | TAG_W | Address uop destination tag |
| sta_addr_i | input | ADDR_W | Address uop address |
| std_valid_i | input | 1 | Data uop valid |
| std_ready_o | output | 1 | Data uop ready |
| std_op_i | input | 9 | Data uop operation type, index in bits 8:6 |
| std_data_i | input | DATA_W | Data uop payload |
| addr_o | output | ADDR_W | Collected address |
| cmp_lo_o | output | DATA_W | Low compare operand |
| cmp_hi_o | output | DATA_W | High compare operand |
| swp_lo_o | output | DATA_W | Low swap operand |
| swp_hi_o | output | DATA_W | High swap operand |
| data_done_o | output | 1 | All required data uops captured |
| sta_got_o | output | 2 | Received flag per address uop (bit 0 index 0, bit 1 index 2) |
| wb_tag0_o | output | TAG_W | Tag for write-back beat 0 |
| wb_tag1_o | output | TAG_W | Tag for write-back beat 1 (quadword) |

## Verification
The plain class is exercised with its single data uop. This shows that index 0 goes to the swap slot rather than the compare slot. Word/doubleword compare-and-swap is fed index 1 before index 0, which shows that completion waits for both and does not depend on order. Quadword is fed data uops in the order 3, 0, 2, 1, and the address uop with index 2 arrives before index 0. This separates the four steering targets and the two tag slots. Further tests send indices the class does not use, a duplicate of a filled slot, and a clear pulse. These tell dropping apart from back-pressure and from resetting the flags.

// File: rtl/amo_col_pkg.sv
package amo_col_pkg;
  localparam int OP_W    = 9;
  localparam int IDX_LSB = 6;
  localparam int IDX_W   = OP_W - IDX_LSB;
  localparam int N_DATA  = 4;
  localparam int N_ADDR  = 2;

  typedef enum logic [1:0] {
    K_PLAIN = 2'd0,
    K_CAS   = 2'd1,
    K_QUAD  = 2'd2,
    K_RSV   = 2'd3
  } kind_e;

  function automatic logic [N_DATA-1:0] need_data(kind_e k);
    case (k)
      K_CAS:   need_data = 4'b0011;
      K_QUAD:  need_data = 4'b1111;
      default: need_data = 4'b0001;
    endcase
  endfunction

  function automatic logic [N_ADDR-1:0] need_addr(kind_e k);
    need_addr = (k == K_QUAD) ? 2'b11 : 2'b01;
  endfunction
endpackage

// File: rtl/amo_col_route.sv
module amo_col_route
  import amo_col_pkg::*;
#(
  parameter bit IS_ADDR = 1'b0,
  parameter int N       = 4
) (
  input  kind_e            kind_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [N-1:0]     hit_o
);
  logic [N-1:0] need;
  logic [N-1:0] pos;

  generate
    if (IS_ADDR) begin : g_addr
      // address uops use indices 0 and 2, mapped to slots 0 and 1
      always_comb begin
        need = N'(need_addr(kind_i));
        pos  = '0;
        if (idx_i == IDX_W'(0)) pos[0] = 1'b1;
        if (idx_i == IDX_W'(2)) pos[N-1] = 1'b1;
      end
    end else begin : g_data
      always_comb begin
        need = N'(need_data(kind_i));
        pos  = '0;
        for (int k = 0; k < N; k++)
          if (idx_i == IDX_W'(k)) pos[k] = 1'b1;
      end
    end
  endgenerate

  assign hit_o = pos & need;
endmodule

// File: rtl/amo_col_slot.sv
module amo_col_slot #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic         full_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_o    <= '0;
      full_o <= 1'b0;
    end else if (clear_i) begin
      full_o <= 1'b0;
    end else if (load_i) begin
      q_o    <= d_i;
      full_o <= 1'b1;
    end
  end

  // R8: a filled slot is never loaded again
  p_no_overwrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !full_o);
  // R8: stored operand holds while filled
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && !clear_i) |=> $stable(q_o));
  // R9: clear empties the slot
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> !full_o);
endmodule

// File: rtl/amo_operand_collector.sv
module amo_operand_collector
  import amo_col_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int DATA_W = 64,
  parameter int TAG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic [1:0]        kind_i,
  input  logic              sta_valid_i,
  output logic              sta_ready_o,
  input  logic [8:0]        sta_op_i,
  input  logic [TAG_W-1:0]  sta_tag_i,
  input  logic [ADDR_W-1:0] sta_addr_i,
  input  logic              std_valid_i,
  output logic              std_ready_o,
  input  logic [8:0]        std_op_i,
  input  logic [DATA_W-1:0] std_data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] cmp_lo_o,
  output logic [DATA_W-1:0] cmp_hi_o,
  output logic [DATA_W-1:0] swp_lo_o,
  output logic [DATA_W-1:0] swp_hi_o,
  output logic              data_done_o,
  output logic [1:0]        sta_got_o,
  output logic [TAG_W-1:0]  wb_tag0_o,
  output logic [TAG_W-1:0]  wb_tag1_o
);
  localparam int AW = TAG_W + ADDR_W;

  kind_e kind;
  assign kind = kind_e'(kind_i);

  logic [N_DATA-1:0] hit_d, load_d, full_d;
  logic [N_ADDR-1:0] hit_a, load_a, full_a;
  logic [DATA_W-1:0] dq [N_DATA];
  logic [AW-1:0]     aq [N_ADDR];
  logic              fire_d, fire_a;

  amo_col_route #(.IS_ADDR(1'b0), .N(N_DATA)) u_route_d (
    .kind_i (kind),
    .idx_i  (std_op_i[OP_W-1:IDX_LSB]),
    .hit_o  (hit_d)
  );

  amo_col_route #(.IS_ADDR(1'b1), .N(N_ADDR)) u_route_a (
    .kind_i (kind),
    .idx_i  (sta_op_i[OP_W-1:IDX_LSB]),
    .hit_o  (hit_a)
  );

  // back-pressure only on an expected uop whose slot is taken
  assign std_ready_o = !clear_i && ((hit_d & full_d) == '0);
  assign sta_ready_o = !clear_i && ((hit_a & full_a) == '0);
  assign fire_d      = std_valid_i && std_ready_o;
  assign fire_a      = sta_valid_i && sta_ready_o;
  assign load_d      = hit_d & {N_DATA{fire_d}};
  assign load_a      = hit_a & {N_ADDR{fire_a}};

  genvar gi;
  generate
    for (gi = 0; gi < N_DATA; gi++) begin : g_dslot
      amo_col_slot #(.W(DATA_W)) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear_i),
        .load_i  (load_d[gi]),
        .d_i     (std_data_i),
        .q_o     (dq[gi]),
        .full_o  (full_d[gi])
      );
    end
    for (gi = 0; gi < N_ADDR; gi++) begin : g_aslot
      amo_col_slot #(.W(AW)) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear_i),
        .load_i  (load_a[gi]),
        .d_i     ({sta_tag_i, sta_addr_i}),
        .q_o     (aq[gi]),
        .full_o  (full_a[gi])
      );
    end
  endgenerate

  logic [N_DATA-1:0] need_d;
  assign need_d = need_data(kind);

  // plain atomics carry their only data uop into the swap slot
  assign swp_lo_o    = (need_d == 4'b0001) ? dq[0] : dq[1];
  assign cmp_lo_o    = dq[0];
  assign cmp_hi_o    = dq[2];
  assign swp_hi_o    = dq[3];
  assign data_done_o = ((full_d & need_d) == need_d);
  assign sta_got_o   = full_a;
  assign addr_o      = aq[0][ADDR_W-1:0];
  assign wb_tag0_o   = aq[0][AW-1:ADDR_W];
  assign wb_tag1_o   = aq[1][AW-1:ADDR_W];

  // R7: unexpected data index leaves flags untouched
  p_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_d && hit_d == '0 && !fire_a) |=> ($stable(data_done_o) && $stable(sta_got_o)));
  // R6: quadword address index 2 marks the high beat received
  p_quad_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sta_valid_i && sta_ready_o && kind_i == 2'd2 && sta_op_i[8:6] == 3'd2)
      |=> sta_got_o[1]);
  // R9: no handshake during clear
  p_clear_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |-> (!sta_ready_o && !std_ready_o));
  // R6: beat-1 flag only rises for quadword class
  p_hi_only_quad_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sta_got_o[1]) |-> $past(kind_i) == 2'd2);
endmodule

// File: tb/amo_operand_collector_tb.sv
module amo_operand_collector_tb;
  localparam int ADDR_W = 48;
  localparam int DATA_W = 64;
  localparam int TAG_W  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear_i = 1'b0;
  logic [1:0] kind_i = 2'd0;
  logic sta_valid_i = 1'b0, std_valid_i = 1'b0;
  logic sta_ready_o, std_ready_o;
  logic [8:0] sta_op_i = '0, std_op_i = '0;
  logic [TAG_W-1:0] sta_tag_i = '0;
  logic [ADDR_W-1:0] sta_addr_i = '0;
  logic [DATA_W-1:0] std_data_i = '0;
  logic [ADDR_W-1:0] addr_o;
  logic [DATA_W-1:0] cmp_lo_o, cmp_hi_o, swp_lo_o, swp_hi_o;
  logic data_done_o;
  logic [1:0] sta_got_o;
  logic [TAG_W-1:0] wb_tag0_o, wb_tag1_o;

  int n_run = 0;
  int n_fail = 0;
  bit last_rdy;

  always #2 clk = ~clk;

  amo_operand_collector #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .kind_i(kind_i),
    .sta_valid_i(sta_valid_i), .sta_ready_o(sta_ready_o), .sta_op_i(sta_op_i),
    .sta_tag_i(sta_tag_i), .sta_addr_i(sta_addr_i),
    .std_valid_i(std_valid_i), .std_ready_o(std_ready_o), .std_op_i(std_op_i),
    .std_data_i(std_data_i), .addr_o(addr_o), .cmp_lo_o(cmp_lo_o),
    .cmp_hi_o(cmp_hi_o), .swp_lo_o(swp_lo_o), .swp_hi_o(swp_hi_o),
    .data_done_o(data_done_o), .sta_got_o(sta_got_o),
    .wb_tag0_o(wb_tag0_o), .wb_tag1_o(wb_tag1_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_std(input logic [2:0] idx, input logic [63:0] d);
    @(negedge clk);
    std_valid_i = 1'b1; std_op_i = {idx, 6'h05}; std_data_i = d;
    #1 last_rdy = std_ready_o;
    @(negedge clk);
    std_valid_i = 1'b0;
  endtask

  task automatic send_sta(input logic [2:0] idx, input logic [7:0] tag, input logic [47:0] a);
    @(negedge clk);
    sta_valid_i = 1'b1; sta_op_i = {idx, 6'h05}; sta_tag_i = tag; sta_addr_i = a;
    #1 last_rdy = sta_ready_o;
    @(negedge clk);
    sta_valid_i = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk);
    clear_i = 1'b1;
    #1 chk("R9 ready low in clear", {62'd0, sta_ready_o, std_ready_o}, 64'd0);
    @(negedge clk);
    clear_i = 1'b0;
    #1 chk("R9 flags after clear", {61'd0, data_done_o, sta_got_o}, 64'd0);
  endtask

  task automatic t_reset();
    #1 chk("R1 got", sta_got_o, 0);
    chk("R1 done", data_done_o, 0);
    chk("R1 ready", {sta_ready_o, std_ready_o}, 2'b11);
  endtask

  task automatic t_plain();
    kind_i = 2'd0;
    chk("R3 not done yet", data_done_o, 0);
    send_std(3'd0, 64'hA1A1);
    chk("R3 done", data_done_o, 1);
    chk("R3 swap lo", swp_lo_o, 64'hA1A1);
    send_sta(3'd0, 8'h11, 48'h1000);
    chk("R6 got0", sta_got_o, 2'b01);
    chk("R6 tag0", wb_tag0_o, 8'h11);
    chk("R6 addr", addr_o, 48'h1000);
    do_clear();
    kind_i = 2'd3;
    send_std(3'd0, 64'hB2B2);
    chk("R2 kind3 as plain", {data_done_o, swp_lo_o}, {1'b1, 64'hB2B2});
    do_clear();
  endtask

  task automatic t_cas();
    kind_i = 2'd1;
    send_std(3'd1, 64'h5555);
    chk("R4 partial", data_done_o, 0);
    send_std(3'd0, 64'hC0C0);
    chk("R4 done", data_done_o, 1);
    chk("R4 cmp lo", cmp_lo_o, 64'hC0C0);
    chk("R4 swap lo", swp_lo_o, 64'h5555);
    send_std(3'd0, 64'hDEAD);
    chk("R8 ready low", last_rdy, 0);
    chk("R8 cmp held", cmp_lo_o, 64'hC0C0);
    do_clear();
  endtask

  task automatic t_quad();
    kind_i = 2'd2;
    send_std(3'd3, 64'h33);
    send_std(3'd0, 64'h10);
    send_std(3'd2, 64'h22);
    chk("R5 three of four", data_done_o, 0);
    send_std(3'd1, 64'h01);
    chk("R5 done", data_done_o, 1);
    chk("R5 operands", {cmp_lo_o[7:0], swp_lo_o[7:0], cmp_hi_o[7:0], swp_hi_o[7:0]}, 32'h10012233);
    send_sta(3'd2, 8'h99, 48'h2000);
    chk("R6 hi first", sta_got_o, 2'b10);
    chk("R6 tag1", wb_tag1_o, 8'h99);
    send_sta(3'd0, 8'h77, 48'h2000);
    chk("R6 both", sta_got_o, 2'b11);
    chk("R6 tag0 quad", wb_tag0_o, 8'h77);
    do_clear();
  endtask

  task automatic t_ignore();
    kind_i = 2'd1;
    send_std(3'd2, 64'hFFFF);
    chk("R7 accepted", last_rdy, 1);
    chk("R7 cmp hi unchanged", cmp_hi_o, 64'h22);
    chk("R7 done unchanged", data_done_o, 0);
    send_sta(3'd2, 8'h55, 48'h3000);
    chk("R7 sta accepted", last_rdy, 1);
    chk("R7 got unchanged", sta_got_o, 2'b00);
    chk("R7 tag1 unchanged", wb_tag1_o, 8'h99);
    kind_i = 2'd2;
    send_std(3'd5, 64'hEEEE);
    chk("R7 idx5 no effect", {data_done_o, cmp_lo_o}, {1'b0, 64'h10});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_plain();
    t_cas();
    t_quad();
    t_ignore();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule